// File: doc/BRIEF.md
# Dual-Bank SDRAM Command State Tracker

This block is a device-side model of the control plane of a two-bank synchronous DRAM. On every rising clock edge it samples the clock-enable pin, the four active-low command strobes and a 12-bit address. It turns each sample into a command code and keeps a state machine for each bank: idle, row open, read burst, write burst, or precharging. It also tracks the global low-power and stall modes that the clock enable drives. These modes are power-down, self-refresh and clock suspend.

Any command that the current state does not allow raises a one-cycle illegal flag and leaves the bank state unchanged. A verification environment or a memory model can use the outputs to track the device: the decoded command, the mode, each bank's state and each bank's open row. Every output is registered. The memory array, the data path and the analog timing are left out.

Top module: `sdr_cmd_tracker`

## Requirements
- R1: With CKE high in normal mode, cmd_o shows one cycle after the sampling edge the code for the strobes. cs_n high gives 0 (deselect). With cs_n low, {ras_n,cas_n,we_n} decodes as follows: 111 gives 1 (no-op), 011 gives 2 (activate), 101 gives 3 (read), 100 gives 4 (write), 010 gives 5 (precharge), 001 gives 6 (auto-refresh), 000 gives 7 (mode set) and 110 gives 8 (burst stop).
- R2: An activate to an idle bank moves that bank to state 1 (row open) and latches addr[10:0] as its row. addr[11] selects the bank and the other bank is unaffected. The bank states are idle=0, open=1, read=2, write=3 and precharge=4. Bank 0 is bank_state_o[2:0] and bank 1 is bank_state_o[5:3]. Bank 0's row is open_row_o[10:0] and bank 1's row is open_row_o[21:11].
- R3: An activate to a bank that is not idle raises illegal_o and changes neither its state nor its row.
- R4: A read or write to a bank that is idle or precharging raises illegal_o and leaves its state unchanged.
- R5: A read or write to an open bank puts it in state 2 or 3 for BURST_LEN cycles. It then returns to state 1 when addr[10] was low.
- R6: When addr[10] was high on the read or write, the bank goes to state 4 for PRE_CYCLES cycles after the burst and then to idle.
- R7: A precharge with addr[10] low closes only the bank that addr[11] selects. With addr[10] high it closes every open bank. A closed bank stays in state 4 for PRE_CYCLES cycles and then goes idle. A precharge to an idle bank is legal and has no effect.
- R8: A read or write accepted on one bank ends a burst in the other bank. That bank goes to state 1, or to state 4 if it had auto-precharge pending. A burst stop ends any burst and returns the bank to state 1.
- R9: CKE sampled low while a bank bursts sets mode_o to 3 (suspend) and cmd_o to 11. The bank states stay frozen while CKE stays low. The edge that samples CKE high returns mode_o to 0 with the banks still held, and the burst then finishes its remaining cycles.
- R10: CKE sampled low with both banks idle and without the self-refresh strobes sets mode_o to 1 (power-down) and cmd_o to 10. While CKE stays low, all other pins are ignored and cmd_o shows 12 (hold). The edge that samples CKE high returns mode_o to 0 and shows cmd_o 12.
- R11: CKE low together with cs_n, ras_n and cas_n low and we_n high, with both banks idle, sets mode_o to 2 (self-refresh) and cmd_o to 9. The mode holds while CKE stays low.
- R12: CKE sampled low in normal mode while a bank has a row open but no burst raises illegal_o. It shows cmd_o 12 and leaves mode_o at 0.
- R13: An auto-refresh or mode-set command while any bank is not idle raises illegal_o.
- R14: After the synchronous reset, cmd_o, mode_o, bank_state_o, open_row_o and illegal_o are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all inputs sampled on the rising edge |
| rst | input | 1 | Synchronous active-high reset |
| cke | input | 1 | Clock enable |
| cs_n | input | 1 | Chip select, active low |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write enable, active low |
| addr | input | 12 | Address: bit 11 bank, bit 10 auto/all-bank precharge, row in 10:0 |
| cmd_o | output | 4 | Decoded command code of the last sample |
| mode_o | output | 2 | Global mode: 0 normal, 1 power-down, 2 self-refresh, 3 suspend |
| bank_state_o | output | 6 | Per-bank state, 3 bits per bank |
| open_row_o | output | 22 | Per-bank latched row, 11 bits per bank |
| illegal_o | output | 1 | Last sampled command was not allowed in the state it met |

## Verification
The hardest case to reach from the ports is a burst in one bank that another bank's command cuts short while that bank has auto-precharge pending. To get there, the stimulus opens both banks, starts an auto-precharge read on one bank, then issues a read to the other bank one cycle later. The bench then checks, cycle by cycle, how the first bank ends its precharge while the second bank's burst goes on. Clock suspend in the middle of a write burst is a second hard case. The bench counts the cycles left in the burst across the frozen cycles and the exit edge, so the point where the burst ends can be predicted from arithmetic alone.

// File: rtl/sdr_trk_pkg.sv
package sdr_trk_pkg;
  typedef enum logic [3:0] {
    C_DESEL = 4'd0, C_NOP = 4'd1, C_ACT = 4'd2, C_READ = 4'd3,
    C_WRITE = 4'd4, C_PRE = 4'd5, C_REF = 4'd6, C_MRS = 4'd7,
    C_BST = 4'd8, C_SREF = 4'd9, C_PDN = 4'd10, C_SUSP = 4'd11,
    C_HOLD = 4'd12
  } cmd_e;

  typedef enum logic [2:0] {
    B_IDLE = 3'd0, B_ACT = 3'd1, B_RD = 3'd2, B_WR = 3'd3, B_PRE = 3'd4
  } bstate_e;

  typedef enum logic [1:0] {
    M_NORM = 2'd0, M_PDN = 2'd1, M_SREF = 2'd2, M_SUSP = 2'd3
  } mode_e;
endpackage

// File: rtl/sdr_cmd_decode.sv
module sdr_cmd_decode
  import sdr_trk_pkg::*;
(
  input  logic cs_n,
  input  logic ras_n,
  input  logic cas_n,
  input  logic we_n,
  output cmd_e pin_cmd
);
  always_comb begin
    if (cs_n) begin
      pin_cmd = C_DESEL;
    end else begin
      unique case ({ras_n, cas_n, we_n})
        3'b111:  pin_cmd = C_NOP;
        3'b011:  pin_cmd = C_ACT;
        3'b101:  pin_cmd = C_READ;
        3'b100:  pin_cmd = C_WRITE;
        3'b010:  pin_cmd = C_PRE;
        3'b001:  pin_cmd = C_REF;
        3'b000:  pin_cmd = C_MRS;
        default: pin_cmd = C_BST;
      endcase
    end
  end
endmodule

// File: rtl/sdr_mode_ctrl.sv
module sdr_mode_ctrl
  import sdr_trk_pkg::*;
(
  input  logic  clk,
  input  logic  rst,
  input  logic  cke,
  input  cmd_e  pin_cmd,
  input  logic  both_idle,
  input  logic  any_burst,
  output mode_e mode_q,
  output cmd_e  rep_cmd,
  output logic  adv_en,
  output logic  bad
);
  mode_e mode_d;

  always_comb begin
    mode_d  = mode_q;
    rep_cmd = pin_cmd;
    adv_en  = 1'b0;
    bad     = 1'b0;
    if (mode_q != M_NORM) begin
      // low-power or stalled: only CKE matters, exit edge is a hold cycle
      rep_cmd = C_HOLD;
      if (cke) mode_d = M_NORM;
    end else if (cke) begin
      adv_en = 1'b1;
      if ((pin_cmd == C_REF || pin_cmd == C_MRS) && !both_idle) bad = 1'b1;
    end else if (both_idle) begin
      if (pin_cmd == C_REF) begin
        mode_d  = M_SREF;
        rep_cmd = C_SREF;
      end else begin
        mode_d  = M_PDN;
        rep_cmd = C_PDN;
      end
    end else if (any_burst) begin
      mode_d  = M_SUSP;
      rep_cmd = C_SUSP;
    end else begin
      rep_cmd = C_HOLD;
      bad     = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) mode_q <= M_NORM;
    else     mode_q <= mode_d;
  end

  AST_LOWPWR_NEEDS_IDLE: assert property (@(posedge clk) disable iff (rst)
    (mode_q == M_NORM && !both_idle) |=> (mode_q != M_PDN && mode_q != M_SREF)); // R12

  AST_MODE_HELD_LOW: assert property (@(posedge clk) disable iff (rst)
    (mode_q != M_NORM && !cke) |=> (mode_q == $past(mode_q))); // R11
endmodule

// File: rtl/sdr_bank_fsm.sv
module sdr_bank_fsm
  import sdr_trk_pkg::*;
#(
  parameter int ROW_W      = 11,
  parameter int BURST_LEN  = 4,
  parameter int PRE_CYCLES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             adv_en,
  input  cmd_e             cmd,
  input  logic             sel,
  input  logic             a10,
  input  logic             other_open,
  input  logic [ROW_W-1:0] row_i,
  output bstate_e          state_q,
  output logic [ROW_W-1:0] row_q,
  output logic             bad
);
  localparam int MAXC  = (BURST_LEN > PRE_CYCLES) ? BURST_LEN : PRE_CYCLES;
  localparam int CNT_W = $clog2(MAXC) + 1;
  localparam logic [CNT_W-1:0] BURST_INIT = CNT_W'(BURST_LEN - 1);
  localparam logic [CNT_W-1:0] PRE_INIT   = CNT_W'(PRE_CYCLES - 1);

  bstate_e          st_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             ap_q, ap_d;
  logic [ROW_W-1:0] row_d;
  logic             is_open, in_burst;

  assign in_burst = (state_q == B_RD) || (state_q == B_WR);
  assign is_open  = in_burst || (state_q == B_ACT);

  always_comb begin
    st_d  = state_q;
    cnt_d = cnt_q;
    ap_d  = ap_q;
    row_d = row_q;
    bad   = 1'b0;
    if (adv_en) begin
      // timed progression
      case (state_q)
        B_RD, B_WR: begin
          if (cnt_q == '0) begin
            if (ap_q) begin
              st_d  = B_PRE;
              cnt_d = PRE_INIT;
            end else begin
              st_d = B_ACT;
            end
          end else begin
            cnt_d = cnt_q - 1'b1;
          end
        end
        B_PRE: begin
          if (cnt_q == '0) st_d = B_IDLE;
          else             cnt_d = cnt_q - 1'b1;
        end
        default: ;
      endcase
      // command effects override the progression
      case (cmd)
        C_ACT: begin
          if (sel) begin
            if (state_q == B_IDLE) begin
              st_d  = B_ACT;
              row_d = row_i;
            end else begin
              bad = 1'b1;
            end
          end
        end
        C_READ, C_WRITE: begin
          if (sel) begin
            if (is_open) begin
              st_d  = (cmd == C_READ) ? B_RD : B_WR;
              cnt_d = BURST_INIT;
              ap_d  = a10;
            end else begin
              bad = 1'b1;
            end
          end else if (other_open && in_burst) begin
            st_d  = ap_q ? B_PRE : B_ACT;
            cnt_d = ap_q ? PRE_INIT : cnt_d;
          end
        end
        C_PRE: begin
          if ((sel || a10) && is_open) begin
            st_d  = B_PRE;
            cnt_d = PRE_INIT;
          end
        end
        C_BST: begin
          if (in_burst) st_d = B_ACT;
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= B_IDLE;
      cnt_q   <= '0;
      ap_q    <= 1'b0;
      row_q   <= '0;
    end else begin
      state_q <= st_d;
      cnt_q   <= cnt_d;
      ap_q    <= ap_d;
      row_q   <= row_d;
    end
  end

  AST_ROW_LATCH: assert property (@(posedge clk) disable iff (rst)
    (adv_en && cmd == C_ACT && sel && state_q == B_IDLE)
      |=> (state_q == B_ACT && row_q == $past(row_i))); // R2

  AST_NO_BURST_FROM_IDLE: assert property (@(posedge clk) disable iff (rst)
    (state_q == B_IDLE) |=> (state_q == B_IDLE || state_q == B_ACT)); // R4

  AST_FROZEN_WHEN_HELD: assert property (@(posedge clk) disable iff (rst)
    !adv_en |=> ($stable(state_q) && $stable(row_q))); // R9

  AST_PRE_ENDS_IDLE: assert property (@(posedge clk) disable iff (rst)
    (state_q == B_PRE) |=> (state_q == B_PRE || state_q == B_IDLE)); // R7
endmodule

// File: rtl/sdr_cmd_tracker.sv
module sdr_cmd_tracker
  import sdr_trk_pkg::*;
#(
  parameter int ADDR_W     = 12,
  parameter int BURST_LEN  = 4,
  parameter int PRE_CYCLES = 2
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  cke,
  input  logic                  cs_n,
  input  logic                  ras_n,
  input  logic                  cas_n,
  input  logic                  we_n,
  input  logic [ADDR_W-1:0]     addr,
  output logic [3:0]            cmd_o,
  output logic [1:0]            mode_o,
  output logic [6-1:0]          bank_state_o,
  output logic [2*(ADDR_W-1)-1:0] open_row_o,
  output logic                  illegal_o
);
  localparam int ROW_W     = ADDR_W - 1;
  localparam int BANK_BIT  = ADDR_W - 1;
  localparam int AP_BIT    = ADDR_W - 2;
  localparam int NUM_BANKS = 2;

  cmd_e    pin_cmd, rep_cmd;
  mode_e   mode_q;
  logic    adv_en, mode_bad;
  bstate_e bst [NUM_BANKS];
  logic [ROW_W-1:0] brow [NUM_BANKS];
  logic [NUM_BANKS-1:0] bank_bad, bank_open, bank_burst, bank_idle;

  sdr_cmd_decode u_dec (
    .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n), .pin_cmd(pin_cmd)
  );

  sdr_mode_ctrl u_mode (
    .clk(clk), .rst(rst), .cke(cke), .pin_cmd(pin_cmd),
    .both_idle(&bank_idle), .any_burst(|bank_burst),
    .mode_q(mode_q), .rep_cmd(rep_cmd), .adv_en(adv_en), .bad(mode_bad)
  );

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    sdr_bank_fsm #(
      .ROW_W(ROW_W), .BURST_LEN(BURST_LEN), .PRE_CYCLES(PRE_CYCLES)
    ) u_bank (
      .clk(clk), .rst(rst), .adv_en(adv_en), .cmd(pin_cmd),
      .sel(addr[BANK_BIT] == 1'(b)), .a10(addr[AP_BIT]),
      .other_open(bank_open[NUM_BANKS-1-b]),
      .row_i(addr[ROW_W-1:0]),
      .state_q(bst[b]), .row_q(brow[b]), .bad(bank_bad[b])
    );
    assign bank_idle[b]  = (bst[b] == B_IDLE);
    assign bank_burst[b] = (bst[b] == B_RD) || (bst[b] == B_WR);
    assign bank_open[b]  = bank_burst[b] || (bst[b] == B_ACT);
    assign bank_state_o[3*b +: 3]       = bst[b];
    assign open_row_o[ROW_W*b +: ROW_W] = brow[b];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cmd_o     <= C_DESEL;
      illegal_o <= 1'b0;
    end else begin
      cmd_o     <= rep_cmd;
      illegal_o <= mode_bad || (|bank_bad);
    end
  end

  assign mode_o = mode_q;

  AST_SUSPEND_FROM_BURST: assert property (@(posedge clk) disable iff (rst)
    (mode_q == M_NORM && !cke && (|bank_burst)) |=> (mode_q == M_SUSP && cmd_o == C_SUSP)); // R9
endmodule

// File: tb/sdr_cmd_tracker_tb_top.sv
module sdr_cmd_tracker_tb_top;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cke = 1'b1, cs_n = 1'b1, ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1;
  logic [11:0] addr = '0;
  logic [3:0]  cmd_o;
  logic [1:0]  mode_o;
  logic [5:0]  bank_state_o;
  logic [21:0] open_row_o;
  logic        illegal_o;
  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  localparam int BL = 4;
  localparam int PC = 2;

  always #5 clk = ~clk;

  sdr_cmd_tracker #(.ADDR_W(12), .BURST_LEN(BL), .PRE_CYCLES(PC)) dut_i (
    .clk(clk), .rst(rst), .cke(cke), .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n),
    .we_n(we_n), .addr(addr), .cmd_o(cmd_o), .mode_o(mode_o),
    .bank_state_o(bank_state_o), .open_row_o(open_row_o), .illegal_o(illegal_o)
  );

  // code: 0 deselect, 1 nop, 2 act, 3 read, 4 write, 5 pre, 6 ref, 7 mrs, 8 bst
  task automatic step(input logic k, input int c, input logic [11:0] a);
    cke  = k;
    addr = a;
    case (c)
      0: {cs_n, ras_n, cas_n, we_n} = 4'b1111;
      1: {cs_n, ras_n, cas_n, we_n} = 4'b0111;
      2: {cs_n, ras_n, cas_n, we_n} = 4'b0011;
      3: {cs_n, ras_n, cas_n, we_n} = 4'b0101;
      4: {cs_n, ras_n, cas_n, we_n} = 4'b0100;
      5: {cs_n, ras_n, cas_n, we_n} = 4'b0010;
      6: {cs_n, ras_n, cas_n, we_n} = 4'b0001;
      7: {cs_n, ras_n, cas_n, we_n} = 4'b0000;
      default: {cs_n, ras_n, cas_n, we_n} = 4'b0110;
    endcase
    @(posedge clk);
    #2;
  endtask

  task automatic chk(input string req, input int act, input int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int st(input int b1, input int b0);
    return b1 * 8 + b0;
  endfunction

  initial begin
    #(200000 * 10);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #2;
    chk("R14 cmd", int'(cmd_o), 0);
    chk("R14 mode", int'(mode_o), 0);
    chk("R14 state", int'(bank_state_o), 0);
    chk("R14 rows", int'(open_row_o), 0);
    chk("R14 illegal", int'(illegal_o), 0);
    rst = 1'b0;

    // R1 decode sweep from all-idle, then return to idle
    for (int c = 0; c <= 8; c++) begin
      step(1, c, 12'h000);
      chk("R1 decode", int'(cmd_o), c);
      chk("R4 rw on idle", int'(illegal_o), (c == 3 || c == 4) ? 1 : 0);
      chk("R2 act state", int'(bank_state_o), (c == 2) ? st(0, 1) : 0);
      step(1, 5, 12'h400);
      step(1, 1, 12'h000);
      step(1, 1, 12'h000);
      chk("R7 back idle", int'(bank_state_o), 0);
    end

    // R2 / R3
    step(1, 2, {1'b1, 11'h5A3});
    chk("R2 state", int'(bank_state_o), st(1, 0));
    chk("R2 row", int'(open_row_o[21:11]), 'h5A3);
    chk("R2 legal", int'(illegal_o), 0);
    step(1, 2, {1'b1, 11'h123});
    chk("R3 illegal", int'(illegal_o), 1);
    chk("R3 row kept", int'(open_row_o[21:11]), 'h5A3);
    chk("R3 state kept", int'(bank_state_o), st(1, 0));
    // R4 read to idle bank 0
    step(1, 3, 12'h005);
    chk("R4 illegal", int'(illegal_o), 1);
    chk("R4 state", int'(bank_state_o), st(1, 0));
    // R13
    step(1, 6, 12'h000);
    chk("R13 ref", int'(illegal_o), 1);
    step(1, 7, 12'h000);
    chk("R13 mrs", int'(illegal_o), 1);
    // R12
    step(0, 1, 12'h000);
    chk("R12 illegal", int'(illegal_o), 1);
    chk("R12 mode", int'(mode_o), 0);
    chk("R12 cmd", int'(cmd_o), 12);
    chk("R12 state", int'(bank_state_o), st(1, 0));

    // R5 read burst without auto-precharge on bank 1
    step(1, 3, 12'h805);
    for (int i = 0; i < BL; i++) begin
      if (i > 0) step(1, 1, 12'h000);
      chk("R5 in burst", int'(bank_state_o), st(2, 0));
    end
    step(1, 1, 12'h000);
    chk("R5 burst end", int'(bank_state_o), st(1, 0));

    // R6 write with auto-precharge on bank 1
    step(1, 4, 12'hC07);
    for (int i = 1; i < BL; i++) step(1, 1, 12'h000);
    chk("R6 last beat", int'(bank_state_o), st(3, 0));
    for (int i = 0; i < PC; i++) begin
      step(1, 1, 12'h000);
      chk("R6 precharging", int'(bank_state_o), st(4, 0));
    end
    step(1, 1, 12'h000);
    chk("R6 idle", int'(bank_state_o), 0);

    // R11 self-refresh
    step(0, 6, 12'h000);
    chk("R11 mode", int'(mode_o), 2);
    chk("R11 cmd", int'(cmd_o), 9);
    step(0, 2, 12'h000);
    chk("R11 held", int'(mode_o), 2);
    chk("R11 ignored", int'(bank_state_o), 0);
    step(1, 1, 12'h000);
    chk("R11 exit", int'(mode_o), 0);

    // R10 power-down
    step(0, 2, 12'h800);
    chk("R10 mode", int'(mode_o), 1);
    chk("R10 cmd", int'(cmd_o), 10);
    step(0, 2, 12'h000);
    chk("R10 hold cmd", int'(cmd_o), 12);
    chk("R10 ignored", int'(bank_state_o), 0);
    step(1, 2, 12'h000);
    chk("R10 exit mode", int'(mode_o), 0);
    chk("R10 exit cmd", int'(cmd_o), 12);
    chk("R10 exit ignored", int'(bank_state_o), 0);

    // R9 clock suspend during a write burst on bank 0
    step(1, 2, 12'h011);
    step(1, 4, 12'h000);
    chk("R9 write", int'(bank_state_o), st(0, 3));
    for (int i = 0; i < 3; i++) begin
      step(0, 1, 12'h000);
      chk("R9 mode", int'(mode_o), 3);
      chk("R9 cmd", int'(cmd_o), (i == 0) ? 11 : 12);
      chk("R9 frozen", int'(bank_state_o), st(0, 3));
    end
    step(1, 1, 12'h000);
    chk("R9 exit", int'(mode_o), 0);
    chk("R9 exit held", int'(bank_state_o), st(0, 3));
    for (int i = 1; i < BL; i++) begin
      step(1, 1, 12'h000);
      chk("R9 resume", int'(bank_state_o), st(0, 3));
    end
    step(1, 1, 12'h000);
    chk("R9 burst done", int'(bank_state_o), st(0, 1));

    // R8 interrupted auto-precharge burst, then burst stop
    step(1, 2, 12'h8AA);
    chk("R8 both open", int'(bank_state_o), st(1, 1));
    step(1, 3, 12'h400);
    chk("R8 read b0", int'(bank_state_o), st(1, 2));
    step(1, 3, 12'h800);
    chk("R8 interrupt", int'(bank_state_o), st(2, 4));
    step(1, 1, 12'h000);
    chk("R8 pre run", int'(bank_state_o), st(2, 4));
    step(1, 1, 12'h000);
    chk("R8 b0 idle", int'(bank_state_o), st(2, 0));
    step(1, 8, 12'h000);
    chk("R8 burst stop", int'(bank_state_o), st(1, 0));

    // R7 single-bank and all-bank precharge
    step(1, 2, 12'h022);
    chk("R7 open", int'(bank_state_o), st(1, 1));
    chk("R7 row b0", int'(open_row_o[10:0]), 'h022);
    step(1, 5, 12'h000);
    chk("R7 single", int'(bank_state_o), st(1, 4));
    step(1, 4, 12'h000);
    chk("R4 write on precharging", int'(illegal_o), 1);
    chk("R7 pre continues", int'(bank_state_o), st(1, 4));
    step(1, 1, 12'h000);
    chk("R7 b0 idle", int'(bank_state_o), st(1, 0));
    step(1, 5, 12'h400);
    chk("R7 all", int'(bank_state_o), st(4, 0));
    chk("R7 legal", int'(illegal_o), 0);
    step(1, 1, 12'h000);
    step(1, 1, 12'h000);
    chk("R7 all idle", int'(bank_state_o), 0);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule